// File: doc/BRIEF.md
# Self-Select Priority Bus Hub

This block joins one bus host to a parameterised set of devices. The host presents an address, a write word, a byte write mask, a read enable and a write enable. The hub copies the address, the write word and the mask to every device port without change. Each device compares the address against its own range and raises an active (self-select) line when the access belongs to it.

The hub passes the active lines through a fixed priority selector, in which device 0 ranks highest. Only the selected device receives the host's read and write enables. Every other device sees both enables low. The host gets back the read word and the ready flag of the selected device. When no device claims the access, the host reads zero and ready stays low.

The hub holds no state. Every output is a function of the current inputs. A host uses it by holding its request until ready rises. A device uses it by driving active from the broadcast address alone.

Top module: `bus_hub`

## Requirements
- R1: Every device port carries the host address, write word and write mask unchanged. Mask bit k qualifies byte k of the word, which is bits 8k+7 down to 8k. The hub keeps these bit positions as they are.
- R2: When one or more active lines are high, the device with the lowest index among them is selected. Device 0 has the highest priority.
- R3: The selected device receives read enable and write enable equal to the host's. Every device that is not selected sees both enables low.
- R4: Host read data and host ready equal the selected device's read word and ready. Read words and ready flags from devices that are not selected have no effect on the host.
- R5: When no active line is high, host read data is all zeros, host ready is 0, and no device sees an enable.
- R6: The hub is purely combinational. Each output follows its inputs within the same clock cycle, with no register on any path.
- R7: Read enable and write enable are routed independently. When the host raises both together, the selected device sees both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| host_addr_i | input | 32 | Host access address |
| host_wdata_i | input | 32 | Host write word |
| host_wmask_i | input | 4 | Host byte write mask, bit k for byte k |
| host_ren_i | input | 1 | Host read enable |
| host_wen_i | input | 1 | Host write enable |
| host_rdata_o | output | 32 | Read word returned to the host |
| host_ready_o | output | 1 | Access complete flag returned to the host |
| dev_addr_o | output | N_DEV x 32 | Address copied to each device |
| dev_wdata_o | output | N_DEV x 32 | Write word copied to each device |
| dev_wmask_o | output | N_DEV x 4 | Write mask copied to each device |
| dev_ren_o | output | N_DEV | Per-device read enable |
| dev_wen_o | output | N_DEV | Per-device write enable |
| dev_ready_i | input | N_DEV | Per-device ready |
| dev_rdata_i | input | N_DEV x 32 | Per-device read word |
| dev_active_i | input | N_DEV | Per-device self-select |

## Verification
Every result of this hub is due in the same cycle as the stimulus that causes it, because there are zero register stages between any input and any output. The bench drives new inputs shortly after each rising edge. It compares every output against a behavioural model at the following falling edge, so each check samples after the inputs have settled and before the next change. Directed cycles cover the idle state, every single-device claim, overlapping claims, no claim, and simultaneous read and write. Random cycles then exercise mixed active patterns, with noise on the read words and ready flags of devices that are not selected.

// File: rtl/bus_hub_pkg.sv
package bus_hub_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned MASK_W = DATA_W / 8;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;
  typedef logic [MASK_W-1:0] mask_t;
endpackage

// File: rtl/hub_prio_sel.sv
module hub_prio_sel #(
  parameter int unsigned N_DEV = 4
) (
  input  logic [N_DEV-1:0] active_i,
  output logic [N_DEV-1:0] grant_o,
  output logic             any_o
);
  logic [N_DEV:0] blocked;

  // lowest index wins; blocked[i] set once any lower index is active
  assign blocked[0] = 1'b0;
  for (genvar i = 0; i < N_DEV; i++) begin : g_chain
    assign grant_o[i]   = active_i[i] & ~blocked[i];
    assign blocked[i+1] = blocked[i] | active_i[i];
  end
  assign any_o = blocked[N_DEV];

  always_comb begin
    assert_grant_onehot_R2: assert ($onehot0(grant_o) && ((|grant_o) == (|active_i)))
      else $error("grant not one-hot or not matching active");
  end

  for (genvar i = 0; i < N_DEV; i++) begin : g_chk
    always_comb begin
      // a granted device must be active, and no lower index may be active
      assert_grant_lowest_R2: assert (!grant_o[i] || (active_i[i] && ((active_i & ((N_DEV'(1) << i) - N_DEV'(1))) == '0)))
        else $error("grant %0d not the lowest active", i);
    end
  end
endmodule

// File: rtl/hub_req_fanout.sv
module hub_req_fanout
  import bus_hub_pkg::*;
#(
  parameter int unsigned N_DEV = 4
) (
  input  logic [N_DEV-1:0]             grant_i,
  input  addr_t                        addr_i,
  input  data_t                        wdata_i,
  input  mask_t                        wmask_i,
  input  logic                         ren_i,
  input  logic                         wen_i,
  output logic [N_DEV-1:0][ADDR_W-1:0] addr_o,
  output logic [N_DEV-1:0][DATA_W-1:0] wdata_o,
  output logic [N_DEV-1:0][MASK_W-1:0] wmask_o,
  output logic [N_DEV-1:0]             ren_o,
  output logic [N_DEV-1:0]             wen_o
);
  for (genvar i = 0; i < N_DEV; i++) begin : g_dev
    assign addr_o[i]  = addr_i;
    assign wdata_o[i] = wdata_i;
    assign wmask_o[i] = wmask_i;
    assign ren_o[i]   = ren_i & grant_i[i];
    assign wen_o[i]   = wen_i & grant_i[i];
  end
endmodule

// File: rtl/hub_rsp_mux.sv
module hub_rsp_mux
  import bus_hub_pkg::*;
#(
  parameter int unsigned N_DEV = 4
) (
  input  logic [N_DEV-1:0]             grant_i,
  input  logic [N_DEV-1:0][DATA_W-1:0] rdata_i,
  input  logic [N_DEV-1:0]             ready_i,
  output data_t                        rdata_o,
  output logic                         ready_o
);
  // grant is one-hot or zero, so an AND-OR tree is a full mux
  always_comb begin
    rdata_o = '0;
    ready_o = 1'b0;
    for (int i = 0; i < N_DEV; i++) begin
      rdata_o = rdata_o | (rdata_i[i] & {DATA_W{grant_i[i]}});
      ready_o = ready_o | (ready_i[i] & grant_i[i]);
    end
  end
endmodule

// File: rtl/bus_hub.sv
module bus_hub
  import bus_hub_pkg::*;
#(
  parameter int unsigned N_DEV = 4
) (
  input  logic [31:0]             host_addr_i,
  input  logic [31:0]             host_wdata_i,
  input  logic [3:0]              host_wmask_i,
  input  logic                    host_ren_i,
  input  logic                    host_wen_i,
  output logic [31:0]             host_rdata_o,
  output logic                    host_ready_o,
  output logic [N_DEV-1:0][31:0]  dev_addr_o,
  output logic [N_DEV-1:0][31:0]  dev_wdata_o,
  output logic [N_DEV-1:0][3:0]   dev_wmask_o,
  output logic [N_DEV-1:0]        dev_ren_o,
  output logic [N_DEV-1:0]        dev_wen_o,
  input  logic [N_DEV-1:0]        dev_ready_i,
  input  logic [N_DEV-1:0][31:0]  dev_rdata_i,
  input  logic [N_DEV-1:0]        dev_active_i
);
  logic [N_DEV-1:0] grant;
  logic             any_active;

  hub_prio_sel #(.N_DEV(N_DEV)) u_sel (
    .active_i (dev_active_i),
    .grant_o  (grant),
    .any_o    (any_active)
  );

  hub_req_fanout #(.N_DEV(N_DEV)) u_req (
    .grant_i  (grant),
    .addr_i   (host_addr_i),
    .wdata_i  (host_wdata_i),
    .wmask_i  (host_wmask_i),
    .ren_i    (host_ren_i),
    .wen_i    (host_wen_i),
    .addr_o   (dev_addr_o),
    .wdata_o  (dev_wdata_o),
    .wmask_o  (dev_wmask_o),
    .ren_o    (dev_ren_o),
    .wen_o    (dev_wen_o)
  );

  hub_rsp_mux #(.N_DEV(N_DEV)) u_rsp (
    .grant_i  (grant),
    .rdata_i  (dev_rdata_i),
    .ready_i  (dev_ready_i),
    .rdata_o  (host_rdata_o),
    .ready_o  (host_ready_o)
  );

  always_comb begin
    assert_idle_quiet_R5: assert (any_active || (host_rdata_o == '0 && !host_ready_o && dev_ren_o == '0 && dev_wen_o == '0))
      else $error("unclaimed access not quiet");
  end

  for (genvar i = 0; i < N_DEV; i++) begin : g_chk
    always_comb begin
      assert_enable_gated_R3: assert (grant[i] || (!dev_ren_o[i] && !dev_wen_o[i]))
        else $error("enable leaked to device %0d", i);
      assert_rsp_routed_R4: assert (!grant[i] || (host_rdata_o == dev_rdata_i[i] && host_ready_o == dev_ready_i[i]))
        else $error("response not from device %0d", i);
      assert_bcast_R1: assert (dev_addr_o[i] == host_addr_i && dev_wdata_o[i] == host_wdata_i && dev_wmask_o[i] == host_wmask_i)
        else $error("broadcast mismatch on device %0d", i);
    end
  end
endmodule

// File: tb/tb_bus_hub.sv
`timescale 1ns/1ps
module tb_bus_hub;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic [31:0]         host_addr, host_wdata, host_rdata;
  logic [3:0]          host_wmask;
  logic                host_ren, host_wen, host_ready;
  logic [N-1:0][31:0]  dev_addr, dev_wdata, dev_rdata;
  logic [N-1:0][3:0]   dev_wmask;
  logic [N-1:0]        dev_ren, dev_wen, dev_ready, dev_active;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  bus_hub #(.N_DEV(N)) dut (
    .host_addr_i (host_addr), .host_wdata_i (host_wdata), .host_wmask_i (host_wmask),
    .host_ren_i (host_ren), .host_wen_i (host_wen),
    .host_rdata_o (host_rdata), .host_ready_o (host_ready),
    .dev_addr_o (dev_addr), .dev_wdata_o (dev_wdata), .dev_wmask_o (dev_wmask),
    .dev_ren_o (dev_ren), .dev_wen_o (dev_wen),
    .dev_ready_i (dev_ready), .dev_rdata_i (dev_rdata), .dev_active_i (dev_active)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference: scan upward for the first claimant
  task automatic compare(input string extra);
    int win = -1;
    logic [N-1:0] e_ren = '0, e_wen = '0;
    logic [31:0]  e_rd = '0;
    logic         e_rdy = 1'b0;
    bit bc_ok = 1'b1;
    for (int k = 0; k < N; k++) if (dev_active[k] && win < 0) win = k;
    if (win >= 0) begin
      e_ren[win] = host_ren;
      e_wen[win] = host_wen;
      e_rd  = dev_rdata[win];
      e_rdy = dev_ready[win];
    end
    for (int k = 0; k < N; k++)
      if (dev_addr[k] !== host_addr || dev_wdata[k] !== host_wdata || dev_wmask[k] !== host_wmask) bc_ok = 1'b0;
    check(bc_ok, {"R1 broadcast", extra}, 64'(dev_addr[0]), 64'(host_addr));
    if (win < 0) begin
      check({dev_ren, dev_wen} === '0, {"R5 enables idle", extra}, 64'({dev_ren, dev_wen}), 64'd0);
      check(host_rdata === 32'd0 && host_ready === 1'b0, {"R5 idle response", extra},
            64'({host_ready, host_rdata}), 64'd0);
    end else begin
      check(dev_ren === e_ren, {"R2 R3 read enable routing", extra}, 64'(dev_ren), 64'(e_ren));
      check(dev_wen === e_wen, {"R2 R3 R7 write enable routing", extra}, 64'(dev_wen), 64'(e_wen));
      check(host_rdata === e_rd && host_ready === e_rdy, {"R4 response routing", extra},
            64'({host_ready, host_rdata}), 64'({e_rdy, e_rd}));
    end
  endtask

  task automatic randomize_data();
    host_addr  = $urandom;
    host_wdata = $urandom;
    host_wmask = 4'($urandom);
    dev_ready  = N'($urandom);
    for (int k = 0; k < N; k++) dev_rdata[k] = $urandom;
  endtask

  task automatic step(input logic [N-1:0] act, input logic ren, input logic wen, input string tag);
    @(posedge clk);
    #1;
    randomize_data();
    dev_active = act;
    host_ren = ren;
    host_wen = wen;
    @(negedge clk);   // R6: results due in the same cycle
    compare(tag);
  endtask

  initial begin
    host_addr = '0; host_wdata = '0; host_wmask = '0; host_ren = 0; host_wen = 0;
    dev_ready = '0; dev_rdata = '0; dev_active = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(host_rdata === 0 && host_ready === 0 && dev_ren === 0 && dev_wen === 0,
          "R5 reset state", 64'({host_ready, host_rdata}), 64'd0);
    // single claimants
    for (int k = 0; k < N; k++) step(N'(1) << k, 1'b1, 1'b0, " single read");
    for (int k = 0; k < N; k++) step(N'(1) << k, 1'b0, 1'b1, " single write");
    // overlap: lowest index wins
    step('1, 1'b1, 1'b0, " all active");
    step(N'(4'b1010), 1'b0, 1'b1, " overlap 1,3");
    step(N'(4'b1100), 1'b1, 1'b0, " overlap 2,3");
    // nobody claims, enables high
    step('0, 1'b1, 1'b1, " unclaimed");
    // R7 both enables together
    step(N'(4'b0100), 1'b1, 1'b1, " R7 both");
    // R6: change active mid-cycle, outputs must follow within the cycle
    @(posedge clk); #1;
    dev_active = N'(4'b0010); host_ren = 1; host_wen = 0;
    #1 dev_active = N'(4'b0001);
    #1 compare(" R6 mid-cycle change");
    for (int c = 0; c < 600; c++)
      step(N'($urandom & $urandom), 1'($urandom), 1'($urandom), " random");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule